// File: doc/BRIEF.md
# Eight-Bit Compare Timer

This block is an 8-bit up-counter paired with a one-byte compare register and one waveform output pin. The counter moves forward only on clock cycles where the tick-enable input is high. That input stands in for an external prescaler. A 2-bit waveform mode picks one of two ways to count. The counter can run freely and wrap. It can also be cleared when it reaches the compare value, so the compare value sets the counting period.

Each compare match sets a sticky compare flag. It also applies one of four pin actions to the output pin: hold, toggle, clear or set. A control write can carry a force strobe. The force strobe applies the chosen pin action at once and has no other effect. An overflow flag records each wrap from the maximum count back to zero. Software clears both flags by writing ones to them.

Software reaches all state through a small write-only register port with four addresses. The counter value, the pin and both flags are visible on output ports.

Top module: `timer8_cmp`

## Requirements
- R1: After reset the counter, compare register, both mode fields, both flags and the pin are all zero.
- R2: The counter changes only on a cycle with tickEn high or on a counter write, and holds its value otherwise.
- R3: When the waveform mode (control bits [1:0]) is 00, 01 or 11, each tick adds one to the counter, which wraps from 0xFF to 0x00 and is never cleared early.
- R4: The overflow flag is set on the tick that takes the counter from 0xFF to 0x00. It stays set until a write to address 3 with bit 0 high. A set in the same cycle wins over the clear.
- R5: When the waveform mode is 10, a tick on which the counter equals the compare register loads zero, so the count repeats every compare+1 ticks.
- R6: A compare match is a tick on which the counter equals the compare register (address 1). It sets the compare flag, which stays set until a write to address 3 with bit 1 high.
- R7: On a compare match the pin follows the compare-output mode (control bits [3:2]): 00 leaves it unchanged, 01 toggles it, 10 clears it, 11 sets it. The new pin value appears one cycle after the tick.
- R8: Writing a new compare-output mode without the force bit leaves the pin as it is. The new mode acts from the next compare match.
- R9: A control write (address 2) with bit 7 high applies the action of the compare-output mode carried in that same write to the pin on the next cycle. It does not set the compare flag and does not change the counter.
- R10: A counter write (address 0) loads the value on the next cycle and takes priority over a tick in the same cycle. The first tick after the write produces no compare match, and so no flag, pin action or clear.
- R11: When a force write and a compare match fall in the same cycle, the pin takes a single action, selected by the mode carried in the force write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable (prescaled tick) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 counter, 1 compare, 2 control, 3 flag clear |
| wrData | input | 8 | Write data |
| cntVal | output | 8 | Current counter value |
| cmpPin | output | 1 | Waveform output pin |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare-match flag |

## Verification
The free-running mode is tried by loading the counter just below 0xFF and ticking across the wrap. This separates a true wrap from an early clear and shows the overflow flag being set and held. The clear-on-compare mode is run with a small compare value under each of the four pin actions. Counting the ticks between clears, and watching the pin after each match, separates the period and each action from its neighbours. Mode changes without force, force writes with each mode, a counter write equal to the compare value, the reserved mode values, and a force write that coincides with a match each isolate one ordering rule. A behavioural model is also compared with all outputs on every cycle.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } pinAct_e;

  localparam logic [1:0] WM_CTC = 2'b10;

  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_CMP = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_FLG = 2'd3;

  localparam int CTL_WM_LO  = 0;
  localparam int CTL_OM_LO  = 2;
  localparam int CTL_FORCE  = 7;
  localparam int FLG_OVF    = 0;
  localparam int FLG_CMP    = 1;

  typedef struct packed {
    logic    loadCnt;
    logic    advance;
    logic    clearCnt;
    logic    pinApply;
    pinAct_e pinAct;
  } dpStrobe_t;

endpackage

// File: rtl/timer8_ctrl.sv
module timer8_ctrl
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] cntVal,
  output dpStrobe_t    strobe,
  output logic         ovfFlag,
  output logic         cmpFlag
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cmpReg;
  logic [1:0]   waveMode;
  pinAct_e      outMode;
  logic         suppress;

  logic wrCnt, wrCmp, wrCtl, wrFlg;
  logic matchNow, forceNow, ctcMode, wrapNow;

  assign wrCnt = wrEn && (wrAddr == ADDR_CNT);
  assign wrCmp = wrEn && (wrAddr == ADDR_CMP);
  assign wrCtl = wrEn && (wrAddr == ADDR_CTL);
  assign wrFlg = wrEn && (wrAddr == ADDR_FLG);

  assign ctcMode  = (waveMode == WM_CTC);
  assign matchNow = tickEn && !wrCnt && !suppress && (cntVal == cmpReg);
  assign forceNow = wrCtl && wrData[CTL_FORCE];
  assign wrapNow  = tickEn && !wrCnt && (cntVal == CNT_MAX);

  always_comb begin
    strobe.loadCnt  = wrCnt;
    strobe.advance  = tickEn && !wrCnt;
    strobe.clearCnt = matchNow && ctcMode;
    strobe.pinApply = matchNow || forceNow;
    strobe.pinAct   = forceNow ? pinAct_e'(wrData[CTL_OM_LO +: 2]) : outMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpReg   <= '0;
      waveMode <= 2'b00;
      outMode  <= OM_HOLD;
    end else begin
      if (wrCmp) cmpReg <= wrData;
      if (wrCtl) begin
        waveMode <= wrData[CTL_WM_LO +: 2];
        outMode  <= pinAct_e'(wrData[CTL_OM_LO +: 2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suppress <= 1'b0;
    end else if (wrCnt) begin
      suppress <= 1'b1;
    end else if (tickEn) begin
      suppress <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      if (wrapNow) ovfFlag <= 1'b1;
      else if (wrFlg && wrData[FLG_OVF]) ovfFlag <= 1'b0;
      if (matchNow) cmpFlag <= 1'b1;
      else if (wrFlg && wrData[FLG_CMP]) cmpFlag <= 1'b0;
    end
  end

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag && !(wrFlg && wrData[FLG_OVF]) |=> ovfFlag);

  assert_cmp_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && !wrCnt && !suppress && (cntVal == cmpReg) |=> cmpFlag);

  assert_force_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    forceNow && !cmpFlag && !matchNow |=> !cmpFlag);

  assert_write_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrCnt |=> !(strobe.pinApply && !wrCtl));

endmodule

// File: rtl/timer8_dp.sv
module timer8_dp
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cntVal,
  output logic         cmpPin
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cntNext;
  logic         pinNext;

  always_comb begin
    cntNext = cntVal;
    if (strobe.loadCnt)       cntNext = loadVal;
    else if (strobe.advance)  cntNext = strobe.clearCnt ? '0 : cntVal + 1'b1;
  end

  always_comb begin
    pinNext = cmpPin;
    if (strobe.pinApply) begin
      unique case (strobe.pinAct)
        OM_TOGGLE: pinNext = !cmpPin;
        OM_CLEAR:  pinNext = 1'b0;
        OM_SET:    pinNext = 1'b1;
        default:   pinNext = cmpPin;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal <= '0;
      cmpPin <= 1'b0;
    end else begin
      cntVal <= cntNext;
      cmpPin <= pinNext;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance && !strobe.loadCnt |=> $stable(cntVal));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !strobe.loadCnt && !strobe.clearCnt && (cntVal == CNT_MAX) |=> cntVal == '0);

  assert_ctc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !strobe.loadCnt && strobe.clearCnt |=> cntVal == '0);

  assert_pin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.pinApply && strobe.pinAct != OM_HOLD) |=> $stable(cmpPin));

endmodule

// File: rtl/timer8_cmp.sv
module timer8_cmp
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cntVal,
  output logic         cmpPin,
  output logic         ovfFlag,
  output logic         cmpFlag
);

  dpStrobe_t strobe;

  timer8_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tickEn  (tickEn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .cntVal  (cntVal),
    .strobe  (strobe),
    .ovfFlag (ovfFlag),
    .cmpFlag (cmpFlag)
  );

  timer8_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .loadVal (wrData),
    .cntVal  (cntVal),
    .cmpPin  (cmpPin)
  );

endmodule

// File: tb/tb_timer8_cmp.sv
module tb_timer8_cmp;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] cntVal;
  logic       cmpPin, ovfFlag, cmpFlag;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // behavioural reference state
  int mCnt = 0, mCmp = 0, mWave = 0, mOm = 0;
  int mPin = 0, mOvf = 0, mCmpF = 0, mSupp = 0;

  always #2 clk = !clk;

  timer8_cmp dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cntVal(cntVal),
    .cmpPin(cmpPin), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 0; mCmp = 0; mWave = 0; mOm = 0;
      mPin = 0; mOvf = 0; mCmpF = 0; mSupp = 0;
    end else begin
      bit wc, tk, match, frc, act;
      int mode;
      wc    = wrEn && wrAddr == 0;
      tk    = tickEn && !wc;
      match = tk && !mSupp && mCnt == mCmp;
      frc   = wrEn && wrAddr == 2 && wrData[7];
      mode  = frc ? int'(wrData[3:2]) : mOm;
      act   = match || frc;
      if (act) begin
        if (mode == 1) mPin = 1 - mPin;
        else if (mode == 2) mPin = 0;
        else if (mode == 3) mPin = 1;
      end
      if (wrEn && wrAddr == 3 && wrData[0]) mOvf = 0;
      if (wrEn && wrAddr == 3 && wrData[1]) mCmpF = 0;
      if (tk && mCnt == 255) mOvf = 1;
      if (match) mCmpF = 1;
      if (wc) begin
        mCnt = int'(wrData); mSupp = 1;
      end else if (tickEn) begin
        mSupp = 0;
        if (match && mWave == 2) mCnt = 0;
        else mCnt = (mCnt + 1) % 256;
      end
      if (wrEn && wrAddr == 1) mCmp = int'(wrData);
      if (wrEn && wrAddr == 2) begin
        mWave = int'(wrData[1:0]); mOm = int'(wrData[3:2]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2/R3/R5 count", int'(cntVal), mCnt);
      chk("R7/R9 pin", int'(cmpPin), mPin);
      chk("R4 ovf", int'(ovfFlag), mOvf);
      chk("R6 cmpflag", int'(cmpFlag), mCmpF);
    end
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tk(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cnt", int'(cntVal), 0);
    chk("R1 pin", int'(cmpPin), 0);
    chk("R1 flags", int'({ovfFlag, cmpFlag}), 0);
    @(negedge clk); @(negedge clk);
    chk("R2 idle hold", int'(cntVal), 0);

    // R3/R4 free-running wrap
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hFD);
    tk(3);
    chk("R3 wrap", int'(cntVal), 0);
    chk("R4 ovf set", int'(ovfFlag), 1);
    tk(2);
    chk("R4 ovf sticky", int'(ovfFlag), 1);
    wr(2'd3, 8'h01);
    chk("R4 ovf w1c", int'(ovfFlag), 0);

    // R5/R6/R7 clear-on-compare with toggle
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h06);
    wr(2'd0, 8'd0);
    tk(5);
    chk("R5 before match", int'(cntVal), 5);
    chk("R6 no flag yet", int'(cmpFlag), 0);
    tk(1);
    chk("R5 ctc clear", int'(cntVal), 0);
    chk("R6 flag set", int'(cmpFlag), 1);
    chk("R7 toggle", int'(cmpPin), 1);
    tk(6);
    chk("R5 period", int'(cntVal), 0);
    chk("R7 toggle back", int'(cmpPin), 0);
    wr(2'd3, 8'h02);
    chk("R6 w1c", int'(cmpFlag), 0);

    // R8 mode change waits for match; R7 set and clear
    wr(2'd2, 8'h0E);
    chk("R8 no change", int'(cmpPin), 0);
    tk(6);
    chk("R7 set", int'(cmpPin), 1);
    wr(2'd2, 8'h0A);
    chk("R8 no change", int'(cmpPin), 1);
    tk(6);
    chk("R7 clear", int'(cmpPin), 0);

    // R9 force strobe
    wr(2'd3, 8'h02);
    wr(2'd2, 8'h8E);
    chk("R9 force set", int'(cmpPin), 1);
    chk("R9 no flag", int'(cmpFlag), 0);
    chk("R9 count kept", int'(cntVal), 0);
    wr(2'd2, 8'h86);
    chk("R9 force toggle", int'(cmpPin), 0);

    // R7 hold mode
    wr(2'd2, 8'h02);
    tk(6);
    chk("R7 hold pin", int'(cmpPin), 0);
    chk("R6 hold flag", int'(cmpFlag), 1);
    wr(2'd2, 8'h82);
    chk("R9 force hold", int'(cmpPin), 0);

    // R10 counter write suppresses next match
    wr(2'd3, 8'h02);
    wr(2'd0, 8'd5);
    chk("R10 load", int'(cntVal), 5);
    tk(1);
    chk("R10 no clear", int'(cntVal), 6);
    chk("R10 no flag", int'(cmpFlag), 0);
    tk(250);
    chk("R4 ctc wrap", int'(cntVal), 0);
    chk("R4 ctc ovf", int'(ovfFlag), 1);

    // R3 reserved mode counts freely
    wr(2'd2, 8'h03);
    tk(10);
    chk("R3 reserved", int'(cntVal), 10);

    // R11 force and match together
    wr(2'd2, 8'h06);
    wr(2'd0, 8'd4);
    tk(1);
    chk("R11 setup", int'(cntVal), 5);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h86;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    chk("R11 single toggle", int'(cmpPin), 1);
    chk("R11 clear", int'(cntVal), 0);
    chk("R11 flag", int'(cmpFlag), 1);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule